// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one external bus transfer at a time on a bus where the low address byte and the data byte share one 8-bit lane. A core presents a request and holds it steady until the controller reports completion. The request carries a memory-or-I/O choice, a read-or-write choice, a 16-bit address and a write byte. Each transfer opens with a one-clock address-latch pulse. During that clock the low address byte is on the lane, so an external transparent latch can keep it. The lane then carries data.

A slow target stretches a transfer by holding the ready input low, which adds wait states. Another bus master asks for the bus with a hold input. The controller lets the running transfer finish, stops driving the bus and acknowledges. Tristating is done in the pad ring, using the two drive-enable outputs. While the bus is granted away, a pending request and the last latched address stay as they were.

The state machine has six states. IDLE waits. T1 sends the address pulse. T2 asserts the strobe and samples ready. TW is a wait state. T3 ends the strobe and completes the transfer. HELD means the bus is granted away. The transitions are:
- IDLE→HELD on hold.
- IDLE→T1 on a request.
- T1→T2 always.
- T2→T3 or TW→T3 when ready is high.
- T2→TW or TW→TW when ready is low.
- T3→HELD on hold, otherwise T3→IDLE.
- HELD→IDLE when hold is low.

Top module: `busctl_top`

## Requirements
- R1: While `rst_n` is low, `rst_out` is high, the strobes are high (inactive), `bus_ale` is low, `lane_oe` and `bus_hlda` are low, `addr_hi` is 00h and `mem_sel` is high. After reset these idle values remain and `rst_out` is low.
- R2: Each transfer gives exactly one clock of `bus_ale` high. In that clock `lane_oe` is 1 and `lane_out` carries address bits 7:0. The strobe for the request direction (`bus_rd_n` for reads, `bus_wr_n` for writes) is then low for 2 clocks when there are no waits.
- R3: Neither strobe is low in a clock where `bus_ale` is high, and the two strobes are never low together.
- R4: On a read, `lane_oe` is 0 while `bus_rd_n` is low. `lane_in` is captured at the clock edge that ends T3. `core_rdata` shows that byte in the clock where `core_done` is high.
- R5: On a write, `lane_oe` is 1 and `lane_out` equals the request's write byte in every clock where `bus_wr_n` is low.
- R6: Every clock edge that ends T2 or TW with `bus_ready` low adds one clock of strobe. The strobe length is 2 plus the number of such edges.
- R7: `mem_sel` is 1 for memory transfers and 0 for I/O transfers throughout the transfer. `addr_hi` carries address bits 15:8 for memory, and address bits 7:0 (the port number) for I/O.
- R8: A hold raised during a transfer lets the transfer complete, with `core_done` as normal. `bus_hlda` is high in the clock after T3. While `bus_hlda` is high, `ctl_oe`, `lane_oe` and `bus_ale` are all 0.
- R9: When `bus_hold` is low at a clock edge while `bus_hlda` is high, `bus_hlda` falls at that edge. `bus_ale` cannot rise before the next clock.
- R10: A request made while the bus is held does not start. After release, it runs with its original address, direction and data. Its `bus_ale` clock comes one clock after `bus_hlda` falls.
- R11: `core_done` is high for exactly one clock per transfer: the clock after T3, which is the first clock with the strobe high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Request pending; held until `core_done` |
| core_io | input | 1 | 1 = I/O transfer, 0 = memory |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Transfer address |
| core_wdata | input | 8 | Write byte |
| core_done | output | 1 | One-clock completion pulse |
| core_rdata | output | 8 | Read byte, valid with `core_done` |
| bus_ready | input | 1 | Target ready; low inserts wait states |
| bus_hold | input | 1 | External master bus request |
| bus_hlda | output | 1 | Bus granted to external master |
| bus_ale | output | 1 | Address latch pulse |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| mem_sel | output | 1 | 1 = memory, 0 = I/O |
| addr_hi | output | 8 | Upper address byte |
| lane_out | output | 8 | Shared lane, outgoing value |
| lane_in | input | 8 | Shared lane, incoming value |
| lane_oe | output | 1 | Drive enable for the shared lane |
| ctl_oe | output | 1 | Drive enable for strobes, select and upper address |
| rst_out | output | 1 | High while reset is applied |

## Verification
The assertions assume that `bus_ready` is meaningful only while a strobe is low. They also assume that the core keeps its request fields stable from raising `core_req` until `core_done`. The stimulus keeps the request frozen for the whole transfer, including time spent in HELD. It drives `bus_ready` from a per-transfer wait count while a strobe is low, and randomly at other times. `bus_hold` is raised only between clock edges, both in idle and partway through a transfer.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
    // Bus cycle phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_HELD
    } bus_state_e;
endpackage

// File: rtl/busctl_fsm.sv
module busctl_fsm
    import busctl_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int ADDR_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_io,
    input  logic              core_wr,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [LANE_W-1:0] core_wdata,
    input  logic              bus_ready,
    input  logic              bus_hold,
    output bus_state_e        state,
    output logic              lat_io,
    output logic              lat_wr,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [LANE_W-1:0] lat_wdata
);
    bus_state_e state_q, state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_hold)      state_d = ST_HELD;
                else if (core_req) state_d = ST_T1;
            end
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = bus_ready ? ST_T3 : ST_TW;
            ST_TW:   state_d = bus_ready ? ST_T3 : ST_TW;
            ST_T3:   state_d = bus_hold ? ST_HELD : ST_IDLE;
            ST_HELD: state_d = bus_hold ? ST_HELD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lat_io    <= 1'b0;
            lat_wr    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_T1) begin
                lat_io    <= core_io;
                lat_wr    <= core_wr;
                lat_addr  <= core_addr;
                lat_wdata <= core_wdata;
            end
        end
    end

    assign state = state_q;
endmodule

// File: rtl/busctl_drive.sv
module busctl_drive
    import busctl_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int ADDR_W = 2 * LANE_W
) (
    input  bus_state_e        state,
    input  logic              lat_io,
    input  logic              lat_wr,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [LANE_W-1:0] lat_wdata,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              mem_sel,
    output logic [LANE_W-1:0] addr_hi,
    output logic [LANE_W-1:0] lane_out,
    output logic              lane_oe,
    output logic              ctl_oe,
    output logic              bus_hlda
);
    logic strobe_on;

    // Output decode per state
    always_comb begin
        bus_ale   = 1'b0;
        strobe_on = 1'b0;
        lane_oe   = 1'b0;
        lane_out  = lat_wdata;
        ctl_oe    = 1'b1;
        bus_hlda  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                bus_ale  = 1'b1;
                lane_oe  = 1'b1;
                lane_out = lat_addr[LANE_W-1:0];
            end
            ST_T2, ST_TW, ST_T3: begin
                strobe_on = 1'b1;
                lane_oe   = lat_wr;
            end
            ST_HELD: begin
                ctl_oe   = 1'b0;
                bus_hlda = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_rd_n = !(strobe_on && !lat_wr);
    assign bus_wr_n = !(strobe_on && lat_wr);
    assign mem_sel  = !lat_io;
    assign addr_hi  = lat_io ? lat_addr[LANE_W-1:0] : lat_addr[ADDR_W-1:LANE_W];
endmodule

// File: rtl/busctl_rdcap.sv
module busctl_rdcap
    import busctl_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              lat_wr,
    input  logic [LANE_W-1:0] lane_in,
    output logic              core_done,
    output logic [LANE_W-1:0] core_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_done  <= 1'b0;
            core_rdata <= '0;
        end else begin
            core_done <= (state == ST_T3);
            if (state == ST_T3 && !lat_wr) core_rdata <= lane_in;
        end
    end
endmodule

// File: rtl/busctl_top.sv
module busctl_top
    import busctl_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int ADDR_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_io,
    input  logic              core_wr,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [LANE_W-1:0] core_wdata,
    output logic              core_done,
    output logic [LANE_W-1:0] core_rdata,
    input  logic              bus_ready,
    input  logic              bus_hold,
    output logic              bus_hlda,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              mem_sel,
    output logic [LANE_W-1:0] addr_hi,
    output logic [LANE_W-1:0] lane_out,
    input  logic [LANE_W-1:0] lane_in,
    output logic              lane_oe,
    output logic              ctl_oe,
    output logic              rst_out
);
    bus_state_e        state;
    logic              lat_io, lat_wr;
    logic [ADDR_W-1:0] lat_addr;
    logic [LANE_W-1:0] lat_wdata;

    busctl_fsm #(.LANE_W(LANE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_io(core_io), .core_wr(core_wr),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .bus_ready(bus_ready), .bus_hold(bus_hold),
        .state(state), .lat_io(lat_io), .lat_wr(lat_wr),
        .lat_addr(lat_addr), .lat_wdata(lat_wdata)
    );

    busctl_drive #(.LANE_W(LANE_W)) u_drive (
        .state(state), .lat_io(lat_io), .lat_wr(lat_wr),
        .lat_addr(lat_addr), .lat_wdata(lat_wdata),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .mem_sel(mem_sel), .addr_hi(addr_hi), .lane_out(lane_out),
        .lane_oe(lane_oe), .ctl_oe(ctl_oe), .bus_hlda(bus_hlda)
    );

    busctl_rdcap #(.LANE_W(LANE_W)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .state(state), .lat_wr(lat_wr),
        .lane_in(lane_in), .core_done(core_done), .core_rdata(core_rdata)
    );

    // Peripherals follow the reset input
    assign rst_out = !rst_n;
endmodule

// File: rtl/busctl_chk.sv
module busctl_chk
    import busctl_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_e        state,
    input logic              bus_ale,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_hlda,
    input logic              bus_hold,
    input logic              bus_ready,
    input logic              ctl_oe,
    input logic              lane_oe,
    input logic              mem_sel,
    input logic [LANE_W-1:0] addr_hi,
    input logic [LANE_W-1:0] lane_out,
    input logic              core_done
);
    // R3
    strobe_off_in_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_rd_n && bus_wr_n));

    // R3
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R2
    ale_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    // R2
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (!bus_rd_n || !bus_wr_n));

    // R4
    read_lane_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !lane_oe);

    // R5
    write_lane_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> lane_oe);

    // R6
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T2 || state == ST_TW) && !bus_ready) |=> (state == ST_TW));

    // R7
    io_port_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && !mem_sel) |-> (addr_hi == lane_out));

    // R8
    held_bus_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hlda |-> (!ctl_oe && !lane_oe && !bus_ale));

    // R8
    hold_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T3 && bus_hold) |=> (bus_hlda && core_done));

    // R9
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hlda && !bus_hold) |=> (!bus_hlda && !bus_ale));

    // R11
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> ($past(!bus_rd_n || !bus_wr_n) && bus_rd_n && bus_wr_n));
endmodule

bind busctl_top busctl_chk #(.LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_hlda(bus_hlda), .bus_hold(bus_hold), .bus_ready(bus_ready),
    .ctl_oe(ctl_oe), .lane_oe(lane_oe), .mem_sel(mem_sel),
    .addr_hi(addr_hi), .lane_out(lane_out), .core_done(core_done)
);

// File: tb/busctl_top_bench.sv
module busctl_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_io = 1'b0, core_wr = 1'b0;
    logic [15:0] core_addr = '0;
    logic [7:0]  core_wdata = '0;
    logic        core_done;
    logic [7:0]  core_rdata;
    logic        bus_ready = 1'b1, bus_hold = 1'b0;
    logic        bus_hlda, bus_ale, bus_rd_n, bus_wr_n, mem_sel;
    logic [7:0]  addr_hi, lane_out;
    logic [7:0]  lane_in = '0;
    logic        lane_oe, ctl_oe, rst_out;

    busctl_top u_busctl_top (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_io(core_io),
        .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_done(core_done), .core_rdata(core_rdata),
        .bus_ready(bus_ready), .bus_hold(bus_hold), .bus_hlda(bus_hlda),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .mem_sel(mem_sel), .addr_hi(addr_hi), .lane_out(lane_out),
        .lane_in(lane_in), .lane_oe(lane_oe), .ctl_oe(ctl_oe), .rst_out(rst_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    // expected transfer
    bit        cur_io, cur_wr;
    bit [15:0] cur_addr;
    bit [7:0]  cur_wdata;
    int        cur_waits;
    // monitor state
    bit [7:0]  latch_lo;
    int        seen;
    bit        prev_ale, prev_strobe, done_seen;

    function automatic bit [7:0] rdata_of(input bit [7:0] hi, input bit [7:0] lo);
        return hi ^ {lo[3:0], lo[7:4]} ^ 8'h3C;
    endfunction

    function automatic bit [7:0] exp_hi();
        return cur_io ? cur_addr[7:0] : cur_addr[15:8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        bit strobe;
        @(negedge clk);
        cyc++;
        if (cyc > WATCHDOG) begin
            chk(1'b0, "watchdog", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        strobe = !bus_rd_n || !bus_wr_n;
        if (rst_n) begin
            chk(!(bus_ale && strobe), "R3 strobe in ale", {bus_rd_n, bus_wr_n}, 2'b11);
            chk(!(!bus_rd_n && !bus_wr_n), "R3 both strobes", {bus_rd_n, bus_wr_n}, 2'b11);
            if (bus_ale) begin
                chk(!prev_ale, "R2 ale width", prev_ale, 0);
                chk(lane_oe && lane_out == cur_addr[7:0], "R2 lane addr", lane_out, cur_addr[7:0]);
                chk(addr_hi == exp_hi(), "R7 addr_hi", addr_hi, exp_hi());
                chk(mem_sel == !cur_io, "R7 mem_sel", mem_sel, !cur_io);
                chk(!bus_hlda, "R8 ale while held", bus_hlda, 0);
                latch_lo = lane_out;
                seen = 0;
            end
            if (strobe) begin
                seen++;
                chk(bus_wr_n == !cur_wr && bus_rd_n == cur_wr, "R2 strobe dir",
                    {bus_rd_n, bus_wr_n}, {cur_wr, !cur_wr});
                if (cur_wr)
                    chk(lane_oe && lane_out == cur_wdata, "R5 write data", {lane_oe, lane_out}, {1'b1, cur_wdata});
                else
                    chk(!lane_oe, "R4 lane released", lane_oe, 0);
                chk(addr_hi == exp_hi() && mem_sel == !cur_io, "R7 hold steady",
                    {mem_sel, addr_hi}, {!cur_io, exp_hi()});
            end
            chk(core_done == (prev_strobe && !strobe), "R11 done timing", core_done, prev_strobe && !strobe);
            if (prev_strobe && !strobe)
                chk(seen == 2 + cur_waits, "R6 strobe length", seen, 2 + cur_waits);
            if (core_done) begin
                done_seen = 1'b1;
                if (!cur_wr)
                    chk(core_rdata == rdata_of(exp_hi(), cur_addr[7:0]), "R4 read data",
                        core_rdata, rdata_of(exp_hi(), cur_addr[7:0]));
            end
            if (bus_hlda)
                chk(!ctl_oe && !lane_oe && !bus_ale, "R8 float", {ctl_oe, lane_oe, bus_ale}, 0);
        end
        prev_ale    = rst_n && bus_ale;
        prev_strobe = rst_n && strobe;
        bus_ready = strobe ? (seen > cur_waits) : 1'($urandom % 2);
        lane_in   = !bus_rd_n ? rdata_of(addr_hi, latch_lo) : 8'($urandom);
    endtask

    task automatic set_req(input bit io, input bit wr, input bit [15:0] a, input bit [7:0] d, input int w);
        cur_io = io; cur_wr = wr; cur_addr = a; cur_wdata = d; cur_waits = w;
        core_io = io; core_wr = wr; core_addr = a; core_wdata = d;
        core_req = 1'b1;
        done_seen = 1'b0;
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 60 && !done_seen; i++) tick();
        chk(done_seen, req, done_seen, 1);
        core_req = 1'b0;
    endtask

    task automatic do_xfer(input bit io, input bit wr, input bit [15:0] a, input bit [7:0] d, input int w);
        set_req(io, wr, a, d, w);
        wait_done("R11 transfer completes");
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0451);
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(rst_out == 1'b1, "R1 rst_out high", rst_out, 1);
            chk(!bus_ale && bus_rd_n && bus_wr_n && !lane_oe && !bus_hlda, "R1 idle strobes",
                {bus_ale, bus_rd_n, bus_wr_n, lane_oe, bus_hlda}, 5'b01100);
            chk(addr_hi == 8'h00 && mem_sel, "R1 addr zero", {mem_sel, addr_hi}, 9'h100);
        end
        rst_n = 1'b1;
        tick();
        chk(!rst_out && ctl_oe && addr_hi == 8'h00 && bus_rd_n && bus_wr_n, "R1 after reset",
            {rst_out, ctl_oe, addr_hi}, {2'b01, 8'h00});

        // Directed corners
        do_xfer(1'b0, 1'b0, 16'h0000, 8'h00, 0);   // R2 memory read, no wait
        do_xfer(1'b0, 1'b1, 16'hFFFF, 8'hA5, 0);   // R5 memory write
        do_xfer(1'b1, 1'b0, 16'h12F0, 8'h00, 1);   // R7 I/O read, one wait
        do_xfer(1'b1, 1'b1, 16'h00FF, 8'h3C, 7);   // R6 I/O write, long wait
        do_xfer(1'b0, 1'b0, 16'h8001, 8'h00, 3);   // R4 read with waits

        // R8/R9/R10: hold while idle, request pending during hold
        bus_hold = 1'b1;
        tick();
        chk(bus_hlda && !ctl_oe, "R8 grant in idle", {bus_hlda, ctl_oe}, 2'b10);
        set_req(1'b0, 1'b1, 16'hBEEF, 8'h77, 1);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!bus_ale && bus_hlda, "R10 no start while held", {bus_ale, bus_hlda}, 2'b01);
        end
        bus_hold = 1'b0;
        tick();
        chk(!bus_hlda && ctl_oe && !bus_ale, "R9 release one clock", {bus_hlda, ctl_oe, bus_ale}, 3'b010);
        tick();
        chk(bus_ale == 1'b1, "R10 pending starts", bus_ale, 1);
        wait_done("R10 pending completes");

        // R8: hold raised mid-transfer
        set_req(1'b0, 1'b0, 16'h4321, 8'h00, 2);
        for (int i = 0; i < 10 && !bus_ale; i++) tick();
        bus_hold = 1'b1;
        for (int i = 0; i < 30 && !done_seen; i++) begin
            tick();
            if (done_seen)
                chk(bus_hlda && !ctl_oe, "R8 grant after cycle", {bus_hlda, ctl_oe}, 2'b10);
        end
        chk(done_seen, "R8 cycle finished under hold", done_seen, 1);
        core_req = 1'b0;
        tick();
        tick();
        chk(bus_hlda, "R8 still held", bus_hlda, 1);
        bus_hold = 1'b0;
        tick();
        chk(!bus_hlda, "R9 hlda drops", bus_hlda, 0);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            do_xfer(1'($urandom % 2), 1'($urandom % 2), 16'($urandom), 8'($urandom), int'($urandom % 4));
            for (int g = 0; g < int'($urandom % 3); g++) tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule